// File: doc/BRIEF.md
# Indirect-Access Serial Channel Register Block

This block is the host-facing register file and command decoder of one asynchronous serial channel. The host sees an 8-bit bus with two live addresses. Address 8 is the data port: writes fill the transmit holding buffer and reads return the last received character. Address 0 is the control port. Every register behind it is reached in two steps. A write taken while the internal pointer is zero names a register, and the next control-port access, whether read or write, acts on that register. The pointer then falls back to zero.

The block holds the channel configuration: receiver and transmitter enables, character lengths, modem control levels, the 16-bit baud time constant and the interrupt enables. It reports a status byte. It decodes the command field of register 0, which clears the break latch, the transmit-pending flag and the interrupt-under-service flag. A write to register 9 performs a per-channel soft reset. Received characters are trimmed to the configured length when they are read. The serial shifters are modelled as plain handshakes: `rx_valid`/`rx_byte` deliver a character, and `tx_req`/`tx_ack` hand one over.

Top module: `sio_regfile`

## Requirements
- R1: A control write (address 0) taken while the pointer is 0 loads the pointer with bits 2:0 of the data, plus 8 when bits 5:3 equal 001. The next control access reads or writes the register with that number, and the pointer then returns to 0. Bus accesses to addresses other than 0 and 8 are ignored.
- R2: A control read with the pointer at 0 returns status. Bit 0 is receive character available, bit 2 is transmit buffer empty and bit 7 is the latched break condition. All other bits read 0.
- R3: A data-port write (address 8) loads the transmit buffer and clears transmit-empty. `tx_req` is high while the buffer is full and the transmitter is enabled, and `tx_byte` shows the buffered value. A `tx_ack` while full empties the buffer.
- R4: An `rx_valid` pulse while the receiver is enabled captures `rx_byte` and sets character available. A data-port read returns the byte ANDed with the mask for length code register3[7:6] (00 gives 0x1F, 01 gives 0x7F, 10 gives 0x3F, 11 gives 0xFF) and clears available. An `rx_valid` pulse while the receiver is disabled is ignored.
- R5: `rx_en` is register3 bit 0 and `rx_len` is register3[7:6]. `tx_en` is register5 bit 3, `tx_len` is register5[6:5], `dtr` is register5 bit 7 and `rts` is register5 bit 1.
- R6: `baud_tc` is {register13, register12}, and `baud_en` is register14 bit 0.
- R7: A register 0 write with bits 5:3 = 010 (0x10) clears the break latch. The latch sets whenever `rx_break` is high.
- R8: A register 0 write with bits 5:3 = 101 (0x28) clears the transmit-pending flag. The flag sets when `tx_ack` empties the buffer and clears on a data-port write.
- R9: `irq_ack` while `irq` is high sets the under-service flag. A register 0 write with bits 5:3 = 111 (0x38) clears it.
- R10: `irq` is high when under-service is clear and either register1 bit 4 is set with a character available, or register1 bit 1 is set with transmit pending.
- R11: A register 9 write with this channel's reset bit set (bit 7 when CHAN_B=0, bit 6 when CHAN_B=1) clears register1, the receiver and transmitter enables, transmit pending and under-service, and empties the transmit buffer. The other channel's bit has no effect.
- R12: After `rst_n`, all registers are 0, the transmit buffer is empty, no character is available, the pointer is 0 and `irq` is low.
- R13: Pointed reads of registers 1, 3, 5, 12, 13 and 14 return the stored values. Pointed reads of any other register number return 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_sel | input | 1 | Bus access strobe, one access per cycle |
| bus_wr | input | 1 | 1 = write, 0 = read |
| bus_addr | input | 4 | 0 = control port, 8 = data port |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data, valid during a read access |
| rx_valid | input | 1 | Received character strobe from the receive shifter |
| rx_byte | input | 8 | Received character |
| rx_break | input | 1 | Break/abort level from the receiver |
| tx_req | output | 1 | Transmit buffer holds a byte for the shifter |
| tx_byte | output | 8 | Buffered transmit byte |
| tx_ack | input | 1 | Shifter has taken the buffered byte |
| irq | output | 1 | Interrupt request |
| irq_ack | input | 1 | Interrupt acknowledge, sets under-service |
| rx_en | output | 1 | Receiver enable |
| rx_len | output | 2 | Receive length code |
| tx_en | output | 1 | Transmitter enable |
| tx_len | output | 2 | Transmit length code |
| dtr | output | 1 | Data terminal ready level |
| rts | output | 1 | Request to send level |
| baud_tc | output | 16 | Baud generator time constant |
| baud_en | output | 1 | Baud generator enable |

## Verification
A pointer that fails to return to zero is the worst internal fault. The next status poll would then silently become a register write or a register read, so the bench reads status right after every pointed access, and a stuck pointer shows up on the very next bus read. A wrong transmit-pending or under-service flag appears on `irq` in the cycle after the causing edge. A wrong receive mask or length decode corrupts the data-port read of the same character. Soft-reset faults appear at once on the enable outputs and in readback.

// File: rtl/sio_pkg.sv
package sio_pkg;

    localparam int DW    = 8;
    localparam int IDX_W = 4;
    localparam int TC_W  = 2 * DW;

    // command field carried in bits 5:3 of a register 0 write
    typedef enum logic [2:0] {
        CMD_NONE    = 3'd0,
        CMD_PT_HI   = 3'd1,
        CMD_EXT_RST = 3'd2,
        CMD_RSV3    = 3'd3,
        CMD_RSV4    = 3'd4,
        CMD_TXP_RST = 3'd5,
        CMD_RSV6    = 3'd6,
        CMD_IUS_RST = 3'd7
    } ctl_cmd_e;

    localparam logic [IDX_W-1:0] RG_CTL = 4'd0;
    localparam logic [IDX_W-1:0] RG_IEN = 4'd1;
    localparam logic [IDX_W-1:0] RG_RXC = 4'd3;
    localparam logic [IDX_W-1:0] RG_TXC = 4'd5;
    localparam logic [IDX_W-1:0] RG_CRS = 4'd9;
    localparam logic [IDX_W-1:0] RG_TCL = 4'd12;
    localparam logic [IDX_W-1:0] RG_TCH = 4'd13;
    localparam logic [IDX_W-1:0] RG_BRG = 4'd14;

    localparam int IEN_RX  = 4;
    localparam int IEN_TX  = 1;
    localparam int RXC_EN  = 0;
    localparam int TXC_EN  = 3;
    localparam int TXC_RTS = 1;
    localparam int TXC_DTR = 7;
    localparam int BRG_EN  = 0;

    function automatic logic [DW-1:0] len_mask(input logic [1:0] code);
        case (code)
            2'b00:   return 8'h1F;
            2'b01:   return 8'h7F;
            2'b10:   return 8'h3F;
            default: return 8'hFF;
        endcase
    endfunction

endpackage

// File: rtl/sio_ptr_seq.sv
module sio_ptr_seq
    import sio_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             ctl_wr,
    input  logic             ctl_rd,
    input  logic [5:0]       cmd_bits,
    output logic [IDX_W-1:0] sel_idx,
    output logic             reg_wr,
    output logic             cmd_wr,
    output ctl_cmd_e         cmd
);

    typedef struct packed {
        logic [IDX_W-1:0] ptr;
    } ptr_st_t;

    ptr_st_t s_d, s_q;
    logic    at_base;

    always_comb begin
        s_d     = s_q;
        cmd     = ctl_cmd_e'(cmd_bits[5:3]);
        at_base = (s_q.ptr == RG_CTL);
        cmd_wr  = ctl_wr && at_base;
        reg_wr  = ctl_wr && !at_base;
        if (cmd_wr) begin
            s_d.ptr = {(cmd == CMD_PT_HI), cmd_bits[2:0]};
        end else if ((ctl_wr || ctl_rd) && !at_base) begin
            s_d.ptr = RG_CTL;
        end
        sel_idx = s_q.ptr;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) s_q <= '0;
        else        s_q <= s_d;
    end

endmodule

// File: rtl/sio_rx_path.sv
module sio_rx_path
    import sio_pkg::*;
(
    input  logic          clk,
    input  logic          rst_n,
    input  logic          rx_valid,
    input  logic [DW-1:0] rx_byte,
    input  logic          rx_on,
    input  logic [1:0]    len_code,
    input  logic          take,
    input  logic          rx_break,
    input  logic          brk_clr,
    output logic          avail,
    output logic          brk,
    output logic [DW-1:0] rd_byte
);

    typedef struct packed {
        logic [DW-1:0] hold;
        logic          avail;
        logic          brk;
    } rx_st_t;

    rx_st_t s_d, s_q;

    always_comb begin
        s_d = s_q;
        if (take) s_d.avail = 1'b0;
        if (rx_valid && rx_on) begin
            s_d.hold  = rx_byte;
            s_d.avail = 1'b1;
        end
        if (brk_clr)  s_d.brk = 1'b0;
        if (rx_break) s_d.brk = 1'b1;
        avail   = s_q.avail;
        brk     = s_q.brk;
        rd_byte = s_q.hold & len_mask(len_code);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) s_q <= '0;
        else        s_q <= s_d;
    end

endmodule

// File: rtl/sio_tx_path.sv
module sio_tx_path
    import sio_pkg::*;
(
    input  logic          clk,
    input  logic          rst_n,
    input  logic          load,
    input  logic [DW-1:0] load_byte,
    input  logic          ack,
    input  logic          tx_on,
    input  logic          pend_clr,
    input  logic          chan_rst,
    output logic          full,
    output logic          pend,
    output logic          req,
    output logic [DW-1:0] out_byte
);

    typedef struct packed {
        logic [DW-1:0] hold;
        logic          full;
        logic          pend;
    } tx_st_t;

    tx_st_t s_d, s_q;

    always_comb begin
        s_d = s_q;
        if (ack && s_q.full) begin
            s_d.full = 1'b0;
            s_d.pend = 1'b1;
        end
        if (pend_clr) s_d.pend = 1'b0;
        if (load) begin
            s_d.hold = load_byte;
            s_d.full = 1'b1;
            s_d.pend = 1'b0;
        end
        if (chan_rst) begin
            s_d.full = 1'b0;
            s_d.pend = 1'b0;
        end
        full     = s_q.full;
        pend     = s_q.pend;
        req      = s_q.full && tx_on;
        out_byte = s_q.hold;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) s_q <= '0;
        else        s_q <= s_d;
    end

endmodule

// File: rtl/sio_regfile.sv
module sio_regfile
    import sio_pkg::*;
#(
    parameter bit CHAN_B = 1'b0
)(
    input  logic            clk,
    input  logic            rst_n,
    input  logic            bus_sel,
    input  logic            bus_wr,
    input  logic [3:0]      bus_addr,
    input  logic [7:0]      bus_wdata,
    output logic [7:0]      bus_rdata,
    input  logic            rx_valid,
    input  logic [7:0]      rx_byte,
    input  logic            rx_break,
    output logic            tx_req,
    output logic [7:0]      tx_byte,
    input  logic            tx_ack,
    output logic            irq,
    input  logic            irq_ack,
    output logic            rx_en,
    output logic [1:0]      rx_len,
    output logic            tx_en,
    output logic [1:0]      tx_len,
    output logic            dtr,
    output logic            rts,
    output logic [15:0]     baud_tc,
    output logic            baud_en
);

    localparam logic [3:0] CTL_ADDR = 4'd0;
    localparam logic [3:0] DAT_ADDR = 4'd8;

    typedef struct packed {
        logic [DW-1:0] ien;
        logic [DW-1:0] rxc;
        logic [DW-1:0] txc;
        logic [DW-1:0] tcl;
        logic [DW-1:0] tch;
        logic [DW-1:0] brg;
        logic          ius;
    } regs_t;

    regs_t r_d, r_q;

    logic             ctl_wr, ctl_rd, dat_wr, dat_rd;
    logic [IDX_W-1:0] ptr_idx;
    logic             reg_wr, cmd_wr;
    ctl_cmd_e         cmd;
    logic             own_rst_bit, chan_rst;
    logic             rx_avail, rx_brk;
    logic [DW-1:0]    rx_rd;
    logic             tx_full, tx_pend;
    logic             pend_clr, brk_clr;
    logic             ius_now;
    logic [DW-1:0]    status;

    assign ctl_wr = bus_sel &&  bus_wr && (bus_addr == CTL_ADDR);
    assign ctl_rd = bus_sel && !bus_wr && (bus_addr == CTL_ADDR);
    assign dat_wr = bus_sel &&  bus_wr && (bus_addr == DAT_ADDR);
    assign dat_rd = bus_sel && !bus_wr && (bus_addr == DAT_ADDR);

    // each channel answers to its own soft-reset bit in register 9
    generate
        if (CHAN_B) begin : g_chan_b
            assign own_rst_bit = bus_wdata[6];
        end else begin : g_chan_a
            assign own_rst_bit = bus_wdata[7];
        end
    endgenerate

    sio_ptr_seq u_ptr (
        .clk      (clk),
        .rst_n    (rst_n),
        .ctl_wr   (ctl_wr),
        .ctl_rd   (ctl_rd),
        .cmd_bits (bus_wdata[5:0]),
        .sel_idx  (ptr_idx),
        .reg_wr   (reg_wr),
        .cmd_wr   (cmd_wr),
        .cmd      (cmd)
    );

    assign pend_clr = cmd_wr && (cmd == CMD_TXP_RST);
    assign brk_clr  = cmd_wr && (cmd == CMD_EXT_RST);

    sio_rx_path u_rx (
        .clk      (clk),
        .rst_n    (rst_n),
        .rx_valid (rx_valid),
        .rx_byte  (rx_byte),
        .rx_on    (r_q.rxc[RXC_EN]),
        .len_code (r_q.rxc[7:6]),
        .take     (dat_rd),
        .rx_break (rx_break),
        .brk_clr  (brk_clr),
        .avail    (rx_avail),
        .brk      (rx_brk),
        .rd_byte  (rx_rd)
    );

    sio_tx_path u_tx (
        .clk       (clk),
        .rst_n     (rst_n),
        .load      (dat_wr),
        .load_byte (bus_wdata),
        .ack       (tx_ack),
        .tx_on     (r_q.txc[TXC_EN]),
        .pend_clr  (pend_clr),
        .chan_rst  (chan_rst),
        .full      (tx_full),
        .pend      (tx_pend),
        .req       (tx_req),
        .out_byte  (tx_byte)
    );

    assign irq = !r_q.ius &&
                 ((r_q.ien[IEN_RX] && rx_avail) || (r_q.ien[IEN_TX] && tx_pend));

    always_comb begin
        r_d      = r_q;
        chan_rst = 1'b0;
        if (reg_wr) begin
            case (ptr_idx)
                RG_IEN:  r_d.ien = bus_wdata;
                RG_RXC:  r_d.rxc = bus_wdata;
                RG_TXC:  r_d.txc = bus_wdata;
                RG_TCL:  r_d.tcl = bus_wdata;
                RG_TCH:  r_d.tch = bus_wdata;
                RG_BRG:  r_d.brg = bus_wdata;
                RG_CRS:  chan_rst = own_rst_bit;
                default: ;
            endcase
        end
        if (irq_ack && irq)                 r_d.ius = 1'b1;
        if (cmd_wr && cmd == CMD_IUS_RST)   r_d.ius = 1'b0;
        if (chan_rst) begin
            r_d.ien         = '0;
            r_d.rxc[RXC_EN] = 1'b0;
            r_d.txc[TXC_EN] = 1'b0;
            r_d.ius         = 1'b0;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) r_q <= '0;
        else        r_q <= r_d;
    end

    assign status = {rx_brk, 4'b0000, !tx_full, 1'b0, rx_avail};

    always_comb begin
        bus_rdata = '0;
        if (ctl_rd) begin
            case (ptr_idx)
                RG_CTL:  bus_rdata = status;
                RG_IEN:  bus_rdata = r_q.ien;
                RG_RXC:  bus_rdata = r_q.rxc;
                RG_TXC:  bus_rdata = r_q.txc;
                RG_TCL:  bus_rdata = r_q.tcl;
                RG_TCH:  bus_rdata = r_q.tch;
                RG_BRG:  bus_rdata = r_q.brg;
                default: bus_rdata = '0;
            endcase
        end else if (dat_rd) begin
            bus_rdata = rx_rd;
        end
    end

    assign ius_now = r_q.ius;
    assign rx_en   = r_q.rxc[RXC_EN];
    assign rx_len  = r_q.rxc[7:6];
    assign tx_en   = r_q.txc[TXC_EN];
    assign tx_len  = r_q.txc[6:5];
    assign dtr     = r_q.txc[TXC_DTR];
    assign rts     = r_q.txc[TXC_RTS];
    assign baud_tc = {r_q.tch, r_q.tcl};
    assign baud_en = r_q.brg[BRG_EN];

endmodule

// File: rtl/sio_regfile_chk.sv
module sio_regfile_chk (
    input logic       clk,
    input logic       rst_n,
    input logic       bus_sel,
    input logic       bus_wr,
    input logic [3:0] bus_addr,
    input logic       own_rst,
    input logic [3:0] ptr,
    input logic       irq,
    input logic       ius,
    input logic       tx_req,
    input logic       tx_en,
    input logic       tx_full,
    input logic       rx_avail,
    input logic       rx_valid,
    input logic       rx_en
);

    // R1: a pointed control access returns the pointer to zero
    a_r1_ptr_returns: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_sel && bus_addr == 4'd0 && ptr != 4'd0) |=> (ptr == 4'd0));

    // R9: nothing requests service while a service is in progress
    a_r9_irq_held_off: assert property (@(posedge clk) disable iff (!rst_n)
        ius |-> !irq);

    // R3: the shifter is only asked for a byte with the transmitter on
    a_r3_req_needs_en: assert property (@(posedge clk) disable iff (!rst_n)
        tx_req |-> tx_en);

    // R3: a data-port write leaves the buffer full
    a_r3_load_fills: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_sel && bus_wr && bus_addr == 4'd8) |=> tx_full);

    // R4: a data-port read consumes the character
    a_r4_read_consumes: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_sel && !bus_wr && bus_addr == 4'd8 && !rx_valid) |=> !rx_avail);

    // R11: soft reset leaves both directions and service state cleared
    a_r11_soft_reset: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_sel && bus_wr && bus_addr == 4'd0 && ptr == 4'd9 && own_rst)
        |=> (!rx_en && !tx_en && !ius && !tx_full));

endmodule

bind sio_regfile sio_regfile_chk u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .bus_sel  (bus_sel),
    .bus_wr   (bus_wr),
    .bus_addr (bus_addr),
    .own_rst  (own_rst_bit),
    .ptr      (ptr_idx),
    .irq      (irq),
    .ius      (ius_now),
    .tx_req   (tx_req),
    .tx_en    (tx_en),
    .tx_full  (tx_full),
    .rx_avail (rx_avail),
    .rx_valid (rx_valid),
    .rx_en    (rx_en)
);

// File: tb/tb_sio_regfile.sv
module tb_sio_regfile;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        bus_sel = 1'b0, bus_wr = 1'b0;
    logic [3:0]  bus_addr = '0;
    logic [7:0]  bus_wdata = '0;
    logic [7:0]  bus_rdata;
    logic        rx_valid = 1'b0;
    logic [7:0]  rx_byte = '0;
    logic        rx_break = 1'b0;
    logic        tx_req;
    logic [7:0]  tx_byte;
    logic        tx_ack = 1'b0;
    logic        irq;
    logic        irq_ack = 1'b0;
    logic        rx_en, tx_en, dtr, rts, baud_en;
    logic [1:0]  rx_len, tx_len;
    logic [15:0] baud_tc;

    int n_chk = 0;
    int n_bad = 0;

    always #5 clk = ~clk;

    sio_regfile #(.CHAN_B(1'b0)) dut (.*);

    function automatic logic [7:0] exp_mask(input logic [1:0] c);
        case (c)
            2'b00:   return 8'h1F;
            2'b01:   return 8'h7F;
            2'b10:   return 8'h3F;
            default: return 8'hFF;
        endcase
    endfunction

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic bus_write(input logic [3:0] a, input logic [7:0] d);
        @(negedge clk);
        bus_sel = 1'b1; bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
        @(negedge clk);
        bus_sel = 1'b0; bus_wr = 1'b0;
    endtask

    task automatic bus_read(input logic [3:0] a, output logic [7:0] d);
        @(negedge clk);
        bus_sel = 1'b1; bus_wr = 1'b0; bus_addr = a;
        #2 d = bus_rdata;
        @(negedge clk);
        bus_sel = 1'b0;
    endtask

    task automatic wr_reg(input logic [3:0] idx, input logic [7:0] v);
        if (idx != 4'd0) bus_write(4'd0, {4'd0, idx});
        bus_write(4'd0, v);
    endtask

    task automatic rd_reg(input logic [3:0] idx, output logic [7:0] d);
        if (idx != 4'd0) bus_write(4'd0, {4'd0, idx});
        bus_read(4'd0, d);
    endtask

    task automatic rx_put(input logic [7:0] b);
        @(negedge clk); rx_valid = 1'b1; rx_byte = b;
        @(negedge clk); rx_valid = 1'b0;
    endtask

    task automatic pulse_tx_ack();
        @(negedge clk); tx_ack = 1'b1;
        @(negedge clk); tx_ack = 1'b0;
    endtask

    task automatic pulse_irq_ack();
        @(negedge clk); irq_ack = 1'b1;
        @(negedge clk); irq_ack = 1'b0;
    endtask

    task automatic summary();
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        n_chk++; n_bad++;
        $display("FAIL watchdog actual=hung expected=done");
        summary();
        $finish;
    end

    initial begin
        logic [7:0] d, s;
        void'($urandom(32'h0C0FFEE5));
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R12 reset state
        chk("R12 rx_en", rx_en, 0);
        chk("R12 tx_en", tx_en, 0);
        chk("R12 baud_tc", baud_tc, 0);
        chk("R12 irq", irq, 0);
        chk("R12 tx_req", tx_req, 0);
        bus_read(4'd0, s);
        chk("R12/R2 status after reset", s, 8'h04);

        // R5/R13/R1 receive configuration and pointer return
        wr_reg(4'd3, 8'hC1);
        chk("R5 rx_en", rx_en, 1);
        chk("R5 rx_len", rx_len, 2'b11);
        rd_reg(4'd3, d);
        chk("R13 readback reg3", d, 8'hC1);
        bus_read(4'd0, s);
        chk("R1 pointer back at status", s, 8'h04);

        // R1 accesses at other addresses are ignored
        bus_write(4'd4, 8'h03);
        bus_read(4'd0, s);
        chk("R1 stray address ignored", s, 8'h04);

        // R5 transmit configuration
        wr_reg(4'd5, 8'hEA);
        chk("R5 tx_en", tx_en, 1);
        chk("R5 tx_len", tx_len, 2'b11);
        chk("R5 dtr", dtr, 1);
        chk("R5 rts", rts, 1);

        // R6 baud constant, random values
        for (int i = 0; i < 12; i++) begin
            logic [15:0] tc;
            tc = 16'($urandom);
            wr_reg(4'd12, tc[7:0]);
            wr_reg(4'd13, tc[15:8]);
            chk("R6 baud_tc", baud_tc, tc);
            rd_reg(4'd13, d);
            chk("R13 readback reg13", d, tc[15:8]);
        end
        wr_reg(4'd14, 8'h01);
        chk("R6 baud_en", baud_en, 1);

        // R4 receive masking across random lengths and bytes
        for (int i = 0; i < 40; i++) begin
            logic [1:0] len;
            logic [7:0] b;
            len = 2'($urandom);
            b   = 8'($urandom);
            wr_reg(4'd3, {len, 5'b0, 1'b1});
            chk("R5 rx_len", rx_len, len);
            rx_put(b);
            bus_read(4'd0, s);
            chk("R4 avail set", s[0], 1);
            bus_read(4'd8, d);
            chk("R4 masked byte", d, b & exp_mask(len));
            bus_read(4'd0, s);
            chk("R4 avail cleared", s[0], 0);
        end
        wr_reg(4'd3, 8'hC0);
        rx_put(8'hA5);
        bus_read(4'd0, s);
        chk("R4 disabled receiver ignores byte", s[0], 0);

        // R3 transmit buffer
        bus_write(4'd8, 8'h5A);
        chk("R3 tx_req", tx_req, 1);
        chk("R3 tx_byte", tx_byte, 8'h5A);
        bus_read(4'd0, s);
        chk("R3 empty cleared", s[2], 0);
        pulse_tx_ack();
        chk("R3 tx_req after ack", tx_req, 0);
        bus_read(4'd0, s);
        chk("R3 empty after ack", s[2], 1);

        // R10/R8/R9 transmit interrupt and service flag
        wr_reg(4'd1, 8'h02);
        chk("R10 tx pending raises irq", irq, 1);
        bus_write(4'd0, 8'h28);
        chk("R8 pending cleared", irq, 0);
        bus_write(4'd8, 8'h33);
        pulse_tx_ack();
        chk("R10 irq after empty", irq, 1);
        pulse_irq_ack();
        chk("R9 under service holds irq off", irq, 0);
        rd_reg(4'd1, d);
        chk("R13 readback reg1", d, 8'h02);
        bus_write(4'd0, 8'h38);
        chk("R9 service cleared", irq, 1);
        bus_write(4'd0, 8'h28);
        chk("R8 pending cleared again", irq, 0);

        // R10 receive interrupt
        wr_reg(4'd1, 8'h10);
        wr_reg(4'd3, 8'hC1);
        rx_put(8'h9C);
        chk("R10 rx irq", irq, 1);
        bus_read(4'd8, d);
        chk("R4 full-width byte", d, 8'h9C);
        chk("R10 rx irq cleared by read", irq, 0);

        // R7 break latch
        @(negedge clk); rx_break = 1'b1;
        @(negedge clk); rx_break = 1'b0;
        bus_read(4'd0, s);
        chk("R7 break latched", s[7], 1);
        bus_write(4'd0, 8'h10);
        bus_read(4'd0, s);
        chk("R7 break cleared", s[7], 0);

        // R13 unimplemented numbers read zero
        rd_reg(4'd7, d);
        chk("R13 reg7 reads zero", d, 0);
        rd_reg(4'd2, d);
        chk("R13 reg2 reads zero", d, 0);

        // R11 soft reset
        wr_reg(4'd1, 8'h12);
        bus_write(4'd8, 8'h44);
        wr_reg(4'd9, 8'h40);
        chk("R11 other channel bit ignored rx_en", rx_en, 1);
        chk("R11 other channel bit ignored tx_en", tx_en, 1);
        rd_reg(4'd1, d);
        chk("R11 other channel bit ignored reg1", d, 8'h12);
        wr_reg(4'd9, 8'h80);
        chk("R11 rx_en cleared", rx_en, 0);
        chk("R11 tx_en cleared", tx_en, 0);
        chk("R11 tx_req low", tx_req, 0);
        chk("R11 irq low", irq, 0);
        rd_reg(4'd1, d);
        chk("R11 reg1 cleared", d, 0);
        bus_read(4'd0, s);
        chk("R11 tx empty", s[2], 1);
        rd_reg(4'd5, d);
        chk("R11 reg5 keeps other bits", d, 8'hE2);
        rd_reg(4'd3, d);
        chk("R11 reg3 keeps length", d, 8'hC0);

        summary();
        $finish;
    end

endmodule